// File: doc/BRIEF.md
# Interrupt Request Steering Unit

This unit sits between a set of peripheral interrupt sources and three possible consumers: a DMA controller, a data transfer controller, and the CPU interrupt path. Each source has a pending flag, set by a one-cycle request pulse. A few control bits per source decide which consumer takes that flag. The bits are a DMA source select, a per-channel DMA enable, one global DMA enable shared by all sources, a transfer-controller enable, and an interrupt-select bit. The unit issues single-cycle activation strobes and source-clear pulses. It raises and holds CPU interrupt requests, and it clears the transfer-controller enable bit by hardware according to the mode.

The transfer controller can run in two modes. With interrupt-select at 1, the CPU is told about every transfer and must re-arm the enable bit itself. With interrupt-select at 0, transfers run silently and the CPU is told only when the remaining count reaches zero. The remaining transfer count of each source arrives as a plain input. The start and done handshakes come from the consumers.

Top module: `irq_steer`

## Requirements
- R1: A source whose DMA select, channel enable and the global DMA enable are all 1 is DMA-routed. Its pending flag produces a one-cycle `dma_act` strobe in the cycle after the flag is visible. One cycle after a cycle in which the source is DMA-routed, its `cpu_irq` is 0, and an interrupt that was already raised is withdrawn.
- R2: A `dma_start` pulse clears the source's pending flag and produces a one-cycle `src_clr` pulse, both visible after the same clock edge.
- R3: A source that is not DMA-routed and has its transfer-controller enable at 1 produces a one-cycle `xc_act` strobe from its pending flag.
- R4: With interrupt-select at 1, an `xc_start` pulse clears the enable bit and raises `cpu_irq`. The pending flag stays set and no `src_clr` pulse is produced. A software write of 1 then re-arms the enable bit.
- R5: With interrupt-select at 0, an `xc_start` pulse clears the pending flag and produces a `src_clr` pulse. The enable bit stays at 1 and no `cpu_irq` is raised.
- R6: With interrupt-select at 0, an `xc_done` pulse while the source's count input is zero clears the enable bit and raises `cpu_irq`. With a non-zero count, `xc_done` changes neither.
- R7: A pending source that is neither DMA-routed nor enabled for the transfer controller raises `cpu_irq` one cycle later, and its pending flag stays set.
- R8: A request pulse sets the pending flag. If a software clear arrives in the same cycle, the set wins.
- R9: `cpu_irq` stays at 1 until a `cpu_ack` pulse, and the ack clears it only when no raise condition holds in the same cycle.
- R10: A software write to the enable bit takes priority over a hardware clear in the same cycle.
- R11: An activation strobe lasts exactly one cycle. No further strobe is issued for that source until a start pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NSRC | Peripheral request pulses |
| sw_clr | input | NSRC | Software clear of pending flags |
| dma_sel | input | NSRC | Source chosen as DMA activator |
| dma_ch_en | input | NSRC | DMA channel enable per source |
| dma_glb_en | input | 1 | Global DMA enable |
| isel | input | NSRC | Interrupt-select per source |
| en_wr | input | NSRC | Software write strobe for the transfer-controller enable |
| en_wdata | input | NSRC | Value written to the enable |
| xfer_cnt | input | NSRC*CNT_W | Remaining transfer count per source, source i at bits i*CNT_W upward |
| dma_start | input | NSRC | DMA controller started a transfer |
| xc_start | input | NSRC | Transfer controller started a transfer |
| xc_done | input | NSRC | Transfer controller finished a transfer |
| cpu_ack | input | NSRC | CPU acknowledges the interrupt |
| dma_act | output | NSRC | DMA activation strobes |
| xc_act | output | NSRC | Transfer-controller activation strobes |
| src_clr | output | NSRC | Hardware source-clear pulses |
| cpu_irq | output | NSRC | CPU interrupt requests |
| xc_en | output | NSRC | Current transfer-controller enable bits |
| pend | output | NSRC | Pending source flags |

## Verification
The hardest case to reach is the withdrawal of an interrupt that was already raised once DMA routing switches on. The source must first be left on the plain CPU path, with the global DMA enable low, until its interrupt is up. The stimulus then raises the global enable alone. That same clock edge should both drop `cpu_irq` and issue the first `dma_act` strobe. A second hard case is the race between a software write and a hardware clear of the enable bit. The bench forces it by driving a write together with a zero-count `xc_done` pulse.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  typedef enum logic [1:0] {
    ROUTE_CPU = 2'd0,
    ROUTE_XC  = 2'd1,
    ROUTE_DMA = 2'd2
  } route_e;

  // DMA routing overrides the transfer controller; otherwise the enable picks it.
  function automatic route_e pick_route(input logic dsel, input logic ch_en,
                                        input logic glb_en, input logic xen);
    if (dsel && ch_en && glb_en) return ROUTE_DMA;
    else if (xen)                return ROUTE_XC;
    else                         return ROUTE_CPU;
  endfunction

endpackage

// File: rtl/irq_steer_flag.sv
module irq_steer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;

  always_ff @(posedge clk) begin
    if (rst)        q_r <= 1'b0;
    else if (set_i) q_r <= 1'b1;
    else if (clr_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  // R8: a set always lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

endmodule

// File: rtl/irq_steer_slot.sv
module irq_steer_slot
  import irq_steer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic sw_clr_i,
  input  logic dsel_i,
  input  logic ch_en_i,
  input  logic glb_en_i,
  input  logic isel_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic cnt_zero_i,
  input  logic dma_start_i,
  input  logic xc_start_i,
  input  logic xc_done_i,
  input  logic ack_i,
  output logic dma_act_o,
  output logic xc_act_o,
  output logic src_clr_o,
  output logic cpu_irq_o,
  output logic xen_o,
  output logic pend_o
);

  logic   pend, busy_q, dma_act_q, xc_act_q, src_clr_q, xen_q;
  route_e route;
  logic   dma_rt, xc_rt, cpu_rt;
  logic   issue_dma, issue_xc, start_seen;
  logic   pend_hw_clr, en_hw_clr, irq_set, irq_clr;

  always_comb begin
    route       = pick_route(dsel_i, ch_en_i, glb_en_i, xen_q);
    dma_rt      = (route == ROUTE_DMA);
    xc_rt       = (route == ROUTE_XC);
    cpu_rt      = (route == ROUTE_CPU);
    issue_dma   = pend & dma_rt & ~busy_q;
    issue_xc    = pend & xc_rt & ~busy_q;
    start_seen  = dma_start_i | xc_start_i;
    pend_hw_clr = dma_start_i | (xc_start_i & ~isel_i);
    en_hw_clr   = (xc_start_i & isel_i) | (xc_done_i & ~isel_i & cnt_zero_i);
    irq_set     = ~dma_rt & (en_hw_clr | (pend & cpu_rt));
    irq_clr     = ack_i | dma_rt;
  end

  irq_steer_flag pend_flag_i (
    .clk(clk), .rst(rst), .set_i(req_i),
    .clr_i(pend_hw_clr | sw_clr_i), .q_o(pend)
  );

  irq_steer_flag irq_flag_i (
    .clk(clk), .rst(rst), .set_i(irq_set),
    .clr_i(irq_clr), .q_o(cpu_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      dma_act_q <= 1'b0;
      xc_act_q  <= 1'b0;
      src_clr_q <= 1'b0;
      xen_q     <= 1'b0;
    end else begin
      if (issue_dma || issue_xc) busy_q <= 1'b1;
      else if (start_seen)       busy_q <= 1'b0;
      dma_act_q <= issue_dma;
      xc_act_q  <= issue_xc;
      src_clr_q <= pend_hw_clr;
      if (en_wr_i)        xen_q <= en_wdata_i;
      else if (en_hw_clr) xen_q <= 1'b0;
    end
  end

  assign dma_act_o = dma_act_q;
  assign xc_act_o  = xc_act_q;
  assign src_clr_o = src_clr_q;
  assign xen_o     = xen_q;
  assign pend_o    = pend;

  // R1: DMA routing keeps the CPU request low
  a_r1_dma_masks_cpu: assert property (@(posedge clk) disable iff (rst)
    $past(dma_rt) |-> !cpu_irq_o);

  // R2: DMA start empties the flag and pulses the clear
  a_r2_dma_start_clears: assert property (@(posedge clk) disable iff (rst)
    (dma_start_i && !req_i) |=> (!pend_o && src_clr_o));

  // R4: select=1 start drops the enable
  a_r4_isel1_drops_en: assert property (@(posedge clk) disable iff (rst)
    (xc_start_i && isel_i && !en_wr_i) |=> !xen_o);

  // R5: select=0 start empties the flag
  a_r5_isel0_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (xc_start_i && !isel_i && !req_i) |=> (!pend_o && src_clr_o));

  // R10: a software write always takes effect
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    en_wr_i |=> (xen_o == $past(en_wdata_i)));

  // R11: strobes never last two cycles
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (dma_act_o || xc_act_o) |=> !(dma_act_o || xc_act_o));

endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NSRC  = 4,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0]         sw_clr,
  input  logic [NSRC-1:0]         dma_sel,
  input  logic [NSRC-1:0]         dma_ch_en,
  input  logic                    dma_glb_en,
  input  logic [NSRC-1:0]         isel,
  input  logic [NSRC-1:0]         en_wr,
  input  logic [NSRC-1:0]         en_wdata,
  input  logic [NSRC*CNT_W-1:0]   xfer_cnt,
  input  logic [NSRC-1:0]         dma_start,
  input  logic [NSRC-1:0]         xc_start,
  input  logic [NSRC-1:0]         xc_done,
  input  logic [NSRC-1:0]         cpu_ack,
  output logic [NSRC-1:0]         dma_act,
  output logic [NSRC-1:0]         xc_act,
  output logic [NSRC-1:0]         src_clr,
  output logic [NSRC-1:0]         cpu_irq,
  output logic [NSRC-1:0]         xc_en,
  output logic [NSRC-1:0]         pend
);

  localparam int CNT_TOTAL = NSRC * CNT_W;

  logic [NSRC-1:0] cnt_zero;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign cnt_zero[i] = (xfer_cnt[i*CNT_W +: CNT_W] == '0);

    irq_steer_slot slot_i (
      .clk(clk), .rst(rst),
      .req_i(req[i]), .sw_clr_i(sw_clr[i]),
      .dsel_i(dma_sel[i]), .ch_en_i(dma_ch_en[i]), .glb_en_i(dma_glb_en),
      .isel_i(isel[i]), .en_wr_i(en_wr[i]), .en_wdata_i(en_wdata[i]),
      .cnt_zero_i(cnt_zero[i]),
      .dma_start_i(dma_start[i]), .xc_start_i(xc_start[i]),
      .xc_done_i(xc_done[i]), .ack_i(cpu_ack[i]),
      .dma_act_o(dma_act[i]), .xc_act_o(xc_act[i]), .src_clr_o(src_clr[i]),
      .cpu_irq_o(cpu_irq[i]), .xen_o(xc_en[i]), .pend_o(pend[i])
    );
  end

  initial begin
    if (CNT_TOTAL != $bits(xfer_cnt)) $error("count bus width mismatch");
  end

endmodule

// File: tb/irq_steer_tb_top.sv
module irq_steer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] req = '0, sw_clr = '0, dma_sel = '0, dma_ch_en = '0;
  logic            dma_glb_en = 1'b0;
  logic [NSRC-1:0] isel = '0, en_wr = '0, en_wdata = '0;
  logic [NSRC*CNT_W-1:0] xfer_cnt = '0;
  logic [NSRC-1:0] dma_start = '0, xc_start = '0, xc_done = '0, cpu_ack = '0;
  logic [NSRC-1:0] dma_act, xc_act, src_clr, cpu_irq, xc_en, pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer #(.NSRC(NSRC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .req(req), .sw_clr(sw_clr), .dma_sel(dma_sel),
    .dma_ch_en(dma_ch_en), .dma_glb_en(dma_glb_en), .isel(isel),
    .en_wr(en_wr), .en_wdata(en_wdata), .xfer_cnt(xfer_cnt),
    .dma_start(dma_start), .xc_start(xc_start), .xc_done(xc_done),
    .cpu_ack(cpu_ack), .dma_act(dma_act), .xc_act(xc_act),
    .src_clr(src_clr), .cpu_irq(cpu_irq), .xc_en(xc_en), .pend(pend)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("reset dma_act", 32'(dma_act), 0);
    chk("reset xc_act", 32'(xc_act), 0);
    chk("reset cpu_irq", 32'(cpu_irq), 0);
    chk("reset xc_en", 32'(xc_en), 0);
    chk("reset pend", 32'(pend), 0);
  endtask

  // source 0 routed to DMA
  task automatic t_dma();
    dma_sel[0] = 1; dma_ch_en[0] = 1; dma_glb_en = 1;
    req[0] = 1; tick(); req[0] = 0;
    chk("R8 pend set", 32'(pend[0]), 1);
    chk("R1 no strobe yet", 32'(dma_act[0]), 0);
    tick();
    chk("R1 dma strobe", 32'(dma_act[0]), 1);
    tick();
    chk("R11 strobe one cycle", 32'(dma_act[0]), 0);
    tick();
    chk("R11 no restrobe before start", 32'(dma_act[0]), 0);
    chk("R1 cpu masked", 32'(cpu_irq[0]), 0);
    dma_start[0] = 1; tick(); dma_start[0] = 0;
    chk("R2 pend cleared", 32'(pend[0]), 0);
    chk("R2 src_clr pulse", 32'(src_clr[0]), 1);
    tick();
    chk("R2 src_clr ends", 32'(src_clr[0]), 0);
  endtask

  // source 0 on CPU path, then DMA global enable withdraws the irq
  task automatic t_mask();
    dma_glb_en = 0;
    req[0] = 1; tick(); req[0] = 0;
    tick();
    chk("R7 cpu path irq", 32'(cpu_irq[0]), 1);
    chk("R1 no dma with glb off", 32'(dma_act[0]), 0);
    dma_glb_en = 1; tick();
    chk("R1 irq withdrawn", 32'(cpu_irq[0]), 0);
    chk("R1 dma strobe after enable", 32'(dma_act[0]), 1);
    dma_start[0] = 1; tick(); dma_start[0] = 0;
    chk("R2 pend cleared again", 32'(pend[0]), 0);
  endtask

  // source 1, interrupt-select 0
  task automatic t_xc_isel0();
    en_wr[1] = 1; en_wdata[1] = 1; tick(); en_wr[1] = 0;
    chk("R10 en written", 32'(xc_en[1]), 1);
    req[1] = 1; tick(); req[1] = 0;
    tick();
    chk("R3 xc strobe", 32'(xc_act[1]), 1);
    xc_start[1] = 1; tick(); xc_start[1] = 0;
    chk("R5 pend cleared", 32'(pend[1]), 0);
    chk("R5 src_clr", 32'(src_clr[1]), 1);
    chk("R5 en kept", 32'(xc_en[1]), 1);
    chk("R5 no irq", 32'(cpu_irq[1]), 0);
    xfer_cnt[15:8] = 8'd3; xc_done[1] = 1; tick(); xc_done[1] = 0;
    chk("R6 nonzero keeps en", 32'(xc_en[1]), 1);
    chk("R6 nonzero no irq", 32'(cpu_irq[1]), 0);
    xfer_cnt[15:8] = 8'd0; xc_done[1] = 1; tick(); xc_done[1] = 0;
    chk("R6 zero drops en", 32'(xc_en[1]), 0);
    chk("R6 zero raises irq", 32'(cpu_irq[1]), 1);
    tick();
    chk("R9 irq held", 32'(cpu_irq[1]), 1);
    cpu_ack[1] = 1; tick(); cpu_ack[1] = 0;
    chk("R9 ack clears", 32'(cpu_irq[1]), 0);
    en_wr[1] = 1; en_wdata[1] = 1; xc_done[1] = 1; tick();
    en_wr[1] = 0; xc_done[1] = 0;
    chk("R10 write beats hw clear", 32'(xc_en[1]), 1);
    cpu_ack[1] = 1; tick(); cpu_ack[1] = 0;
    chk("R9 ack clears again", 32'(cpu_irq[1]), 0);
  endtask

  // source 2, interrupt-select 1
  task automatic t_xc_isel1();
    isel[2] = 1;
    en_wr[2] = 1; en_wdata[2] = 1; tick(); en_wr[2] = 0;
    req[2] = 1; tick(); req[2] = 0;
    tick();
    chk("R3 xc strobe isel1", 32'(xc_act[2]), 1);
    xc_start[2] = 1; tick(); xc_start[2] = 0;
    chk("R4 en cleared", 32'(xc_en[2]), 0);
    chk("R4 irq raised", 32'(cpu_irq[2]), 1);
    chk("R4 pend kept", 32'(pend[2]), 1);
    chk("R4 no src_clr", 32'(src_clr[2]), 0);
    tick();
    chk("R9 irq held isel1", 32'(cpu_irq[2]), 1);
    sw_clr[2] = 1; tick(); sw_clr[2] = 0;
    chk("R8 sw clear", 32'(pend[2]), 0);
    cpu_ack[2] = 1; tick(); cpu_ack[2] = 0;
    chk("R9 ack isel1", 32'(cpu_irq[2]), 0);
    en_wr[2] = 1; en_wdata[2] = 1; tick(); en_wr[2] = 0;
    chk("R4 sw re-arm", 32'(xc_en[2]), 1);
  endtask

  // source 3, no consumer claims it
  task automatic t_default();
    req[3] = 1; tick(); req[3] = 0;
    tick();
    chk("R7 irq raised", 32'(cpu_irq[3]), 1);
    chk("R7 pend held", 32'(pend[3]), 1);
    cpu_ack[3] = 1; tick(); cpu_ack[3] = 0;
    chk("R9 raise beats ack", 32'(cpu_irq[3]), 1);
    sw_clr[3] = 1; tick(); sw_clr[3] = 0;
    cpu_ack[3] = 1; tick(); cpu_ack[3] = 0;
    chk("R9 ack after clear", 32'(cpu_irq[3]), 0);
  endtask

  task automatic t_setwins();
    req[3] = 1; sw_clr[3] = 1; tick(); req[3] = 0; sw_clr[3] = 0;
    chk("R8 set beats clear", 32'(pend[3]), 1);
    sw_clr[3] = 1; tick(); sw_clr[3] = 0;
    chk("R8 clear alone", 32'(pend[3]), 0);
    cpu_ack[3] = 1; tick(); cpu_ack[3] = 0;
    chk("R9 final ack", 32'(cpu_irq[3]), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_dma();
    t_mask();
    t_xc_isel0();
    t_xc_isel1();
    t_default();
    t_setwins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule